// File: doc/BRIEF.md
# Serial Memory Programming Slave

This block lets an external programmer load, inspect and clear two on-chip storage arrays over a four-wire serial link while the device is held in its programming reset. The programmer supplies the serial clock and drives one data line. The block drives the other data line back. It stores a word-wide program array and a byte-wide data array in separate address spaces. Every transaction is a 32-bit frame sent most significant bit first, made of an opcode byte, two address bytes and a data byte.

A session starts when the programming reset line is pulled low. The first frame the block acts on must be an enable frame. Write and clear frames that arrive before it are dropped. Writes and the full clear are self-timed: each accepted one raises a busy flag for a set number of system clocks. A data-array write replaces the old byte without needing a clear first. The serial inputs are sampled through synchronisers on the system clock, so the serial clock must be much slower than the system clock.

Opcodes: `AC 53 xx xx` enable, `AC 80 xx xx` clear all, `20`/`28` read program low/high byte, `40`/`48` write program low/high byte, `A0` read data byte, `C0` write data byte. The program word address is `{byte1,byte2}` reduced to 9 bits. The data-array address is `byte2` reduced to 6 bits.

Top module: `serprog_slave`

## Requirements
- R1: While `prog_rst_n` is high, frames have no effect: nothing is written, `busy` stays low and `miso` stays 0.
- R2: After `prog_rst_n` falls, write and clear frames are discarded, and `busy` stays low, until an enable frame (`AC 53`) has completed. Read frames return 0 before enable.
- R3: During the third byte of an enable frame, `miso` returns the second byte received (0x53), MSB first.
- R4: A clear frame (`AC 80`) sets every word of the program array to 0xFFFF and every byte of the data array to 0xFF.
- R5: A data write (`C0 xx addr data`) stores `data` at `addr`, whatever the old content was. A read (`A0 xx addr xx`) returns that byte on `miso` during the fourth byte.
- R6: Program writes `40` and `48` set only the low or only the high byte of word `{byte1,byte2}`. Reads `20` and `28` return that byte during the fourth byte.
- R7: Address bits above the array size are ignored. Program addresses wrap at 512 words and data addresses wrap at 64 bytes.
- R8: An accepted write or clear holds `busy` high for exactly `BUSY_CYCLES` system clocks. Write and clear frames that complete while `busy` is high are ignored. `busy` is low after reset.
- R9: Raising `prog_rst_n` clears the enable state and the frame bit counter, even in the middle of a frame. The next session must send the enable frame again.
- R10: Outside the echo byte and the read-data byte, `miso` is 0. Both `miso` and `busy` are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| prog_rst_n | input | 1 | Programming reset; low selects programming mode |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data from the programmer, sampled on the rising edge of `sck` |
| miso | output | 1 | Serial data to the programmer, valid before each rising edge of `sck` |
| busy | output | 1 | High while a self-timed write or clear runs |

## Verification
Each serial input passes through two synchroniser flops and one edge register. A frame therefore completes about four system clocks after the final `sck` rise, and `busy` rises on the next clock. The bench samples `busy` only after holding `sck` steady for five clocks plus four more settle clocks. A reply byte is loaded into the output register about four clocks after the rise that ends the byte before it. The bench reads each `miso` bit at the end of a full low half-period, just before it raises `sck`, so the bit has been stable for several clocks. The checker counts the exact length of each `busy` pulse. The bench then waits on `busy` itself before it issues the next frame.

// File: rtl/serprog_pkg.sv
// Package: opcode values and command decode shared by the programming slave.
// Assumes a 32-bit frame with the opcode in the top byte and a sub-opcode in byte 1.
package serprog_pkg;

    localparam logic [7:0] OP_SPECIAL = 8'hAC;
    localparam logic [7:0] SUB_ENABLE = 8'h53;
    localparam logic [7:0] SUB_CLEAR  = 8'h80;
    localparam logic [7:0] OP_PRD_LO  = 8'h20;
    localparam logic [7:0] OP_PRD_HI  = 8'h28;
    localparam logic [7:0] OP_PWR_LO  = 8'h40;
    localparam logic [7:0] OP_PWR_HI  = 8'h48;
    localparam logic [7:0] OP_ERD     = 8'hA0;
    localparam logic [7:0] OP_EWR     = 8'hC0;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_ENABLE,
        CMD_CLEAR,
        CMD_PWR_LO,
        CMD_PWR_HI,
        CMD_EWR
    } cmd_e;

    // Map the opcode and sub-opcode bytes of a finished frame to a state-changing command.
    function automatic cmd_e decode_cmd(input logic [7:0] op, input logic [7:0] sub);
        cmd_e c;
        c = CMD_NONE;
        case (op)
            OP_SPECIAL: begin
                if (sub == SUB_ENABLE)     c = CMD_ENABLE;
                else if (sub == SUB_CLEAR) c = CMD_CLEAR;
            end
            OP_PWR_LO: c = CMD_PWR_LO;
            OP_PWR_HI: c = CMD_PWR_HI;
            OP_EWR:    c = CMD_EWR;
            default:   c = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/serprog_frame_rx.sv
// Serial frame engine: synchronises sck/mosi/prog_rst_n into clk, shifts in
// 32-bit frames MSB first on sck rising edges, and shifts out a reply byte.
// Assumes the sck half period is several clk cycles longer than SYNC.
// A reply byte (tx_byte) is loaded one clk after the rise that completes
// 16 or 24 bits. It shifts out on later rises, after the master has sampled.
module serprog_frame_rx #(
    parameter int SYNC      = 2,
    parameter int FRAME_BITS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  prog_rst_n,
    input  logic                  sck,
    input  logic                  mosi,
    input  logic [7:0]            tx_byte,
    output logic                  active,
    output logic                  frame_done,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic [$clog2(FRAME_BITS)-1:0] bit_cnt,
    output logic                  miso
);
    localparam int CW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST   = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] AT_B2  = CW'(16);
    localparam logic [CW-1:0] AT_B3  = CW'(24);

    logic [SYNC-1:0] sck_sy, mosi_sy, prst_sy;
    logic            sck_prev, rise, rise_d;
    logic [7:0]      out_sr;

    // Bring the asynchronous serial pins into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sy   <= '0;
            mosi_sy  <= '0;
            prst_sy  <= '1;
            sck_prev <= 1'b0;
        end else begin
            sck_sy   <= {sck_sy[SYNC-2:0], sck};
            mosi_sy  <= {mosi_sy[SYNC-2:0], mosi};
            prst_sy  <= {prst_sy[SYNC-2:0], prog_rst_n};
            sck_prev <= sck_sy[SYNC-1];
        end
    end

    assign rise   = sck_sy[SYNC-1] & ~sck_prev;
    assign active = ~prst_sy[SYNC-1];

    // Shift frames in, count bits, and run the reply shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word    <= '0;
            bit_cnt    <= '0;
            out_sr     <= '0;
            rise_d     <= 1'b0;
            frame_done <= 1'b0;
        end else if (!active) begin
            bit_cnt    <= '0;
            out_sr     <= '0;
            rise_d     <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            rise_d     <= rise;
            frame_done <= 1'b0;
            if (rise) begin
                rx_word <= {rx_word[FRAME_BITS-2:0], mosi_sy[SYNC-1]};
                bit_cnt <= bit_cnt + 1'b1;
                out_sr  <= {out_sr[6:0], 1'b0};
                if (bit_cnt == LAST) frame_done <= 1'b1;
            end else if (rise_d && (bit_cnt == AT_B2 || bit_cnt == AT_B3)) begin
                out_sr <= tx_byte;
            end
        end
    end

    assign miso = out_sr[7];

endmodule

// File: rtl/serprog_ctrl.sv
// Command controller: acts on finished frames. It tracks the enable state and
// issues write and clear strobes. The busy counter models self-timed operations.
// Assumes frame_done is a one-cycle pulse with the frame stable on rx_word.
module serprog_ctrl
    import serprog_pkg::*;
#(
    parameter int BUSY_CYCLES = 2000,
    parameter int PA_W        = 9,
    parameter int EA_W        = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            frame_done,
    input  logic [31:0]     frame,
    output logic            en_q,
    output logic            busy,
    output logic            clear,
    output logic            p_we,
    output logic [1:0]      p_lane,
    output logic [PA_W-1:0] p_waddr,
    output logic            e_we,
    output logic [EA_W-1:0] e_waddr,
    output logic [7:0]      wbyte
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);

    logic [BW-1:0] busy_cnt;
    logic [15:0]   addr_full;
    cmd_e          cmd;
    logic          may_write;

    assign cmd       = decode_cmd(frame[31:24], frame[23:16]);
    assign addr_full = frame[23:8];
    assign may_write = frame_done && en_q && !busy;

    assign clear   = may_write && (cmd == CMD_CLEAR);
    assign p_we    = may_write && (cmd == CMD_PWR_LO || cmd == CMD_PWR_HI);
    assign p_lane  = (cmd == CMD_PWR_HI) ? 2'b10 : 2'b01;
    assign e_we    = may_write && (cmd == CMD_EWR);
    assign p_waddr = addr_full[PA_W-1:0];
    assign e_waddr = addr_full[EA_W-1:0];
    assign wbyte   = frame[7:0];
    assign busy    = (busy_cnt != '0);

    // Enable state: set by an enable frame, lost whenever the link is inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)                        en_q <= 1'b0;
        else if (frame_done && cmd == CMD_ENABLE)     en_q <= 1'b1;
    end

    // Self-timed operation counter: loaded by any accepted write or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                      busy_cnt <= '0;
        else if (clear || p_we || e_we)  busy_cnt <= BW'(BUSY_CYCLES);
        else if (busy)                   busy_cnt <= busy_cnt - 1'b1;
    end

endmodule

// File: rtl/serprog_array.sv
// Storage array with byte-lane writes, a single-cycle fill with ones,
// and a combinational read port. Content is not reset: it models
// non-volatile cells, so it survives rst_n.
module serprog_array #(
    parameter int WORDS = 64,
    parameter int LANES = 1
) (
    input  logic                     clk,
    input  logic                     fill,
    input  logic                     we,
    input  logic [LANES-1:0]         lane_en,
    input  logic [$clog2(WORDS)-1:0] waddr,
    input  logic [7:0]               wdata,
    input  logic [$clog2(WORDS)-1:0] raddr,
    output logic [LANES*8-1:0]       rdata
);
    logic [LANES*8-1:0] cells [WORDS];

    // Each lane is an independent byte column with its own write enable.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Update one byte column: a clear fills it with ones, a write stores one byte.
        always_ff @(posedge clk) begin
            if (fill) begin
                for (int w = 0; w < WORDS; w++) cells[w][l*8 +: 8] <= 8'hFF;
            end else if (we && lane_en[l]) begin
                cells[waddr][l*8 +: 8] <= wdata;
            end
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/serprog_slave.sv
// Top: serial programming slave for a program array and a data array.
// Assumes clk is much faster than sck (half period of sck > SYNC+3 clks).
// MISO replies: the echo of byte 1 in byte 2 of an enable frame, and read data in byte 3.
module serprog_slave
    import serprog_pkg::*;
#(
    parameter int PROG_WORDS  = 512,
    parameter int DATA_BYTES  = 64,
    parameter int BUSY_CYCLES = 2000,
    parameter int SYNC        = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_rst_n,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic busy
);
    localparam int PA_W = $clog2(PROG_WORDS);
    localparam int EA_W = $clog2(DATA_BYTES);

    logic            active, frame_done, en_q, clear, p_we, e_we;
    logic [31:0]     rx_word;
    logic [4:0]      bit_cnt;
    logic [7:0]      tx_byte, wbyte, e_rdata;
    logic [1:0]      p_lane;
    logic [15:0]     p_rdata, rd_full;
    logic [PA_W-1:0] p_waddr;
    logic [EA_W-1:0] e_waddr;

    serprog_frame_rx #(.SYNC(SYNC), .FRAME_BITS(32)) u_rx (
        .clk(clk), .rst_n(rst_n), .prog_rst_n(prog_rst_n), .sck(sck), .mosi(mosi),
        .tx_byte(tx_byte), .active(active), .frame_done(frame_done),
        .rx_word(rx_word), .bit_cnt(bit_cnt), .miso(miso)
    );

    serprog_ctrl #(.BUSY_CYCLES(BUSY_CYCLES), .PA_W(PA_W), .EA_W(EA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .active(active), .frame_done(frame_done),
        .frame(rx_word), .en_q(en_q), .busy(busy), .clear(clear),
        .p_we(p_we), .p_lane(p_lane), .p_waddr(p_waddr),
        .e_we(e_we), .e_waddr(e_waddr), .wbyte(wbyte)
    );

    // Read address during a frame: bytes 1 and 2 sit in the low 16 bits after 24 bits.
    assign rd_full = rx_word[15:0];

    serprog_array #(.WORDS(PROG_WORDS), .LANES(2)) u_prog (
        .clk(clk), .fill(clear), .we(p_we), .lane_en(p_lane), .waddr(p_waddr),
        .wdata(wbyte), .raddr(rd_full[PA_W-1:0]), .rdata(p_rdata)
    );

    serprog_array #(.WORDS(DATA_BYTES), .LANES(1)) u_data (
        .clk(clk), .fill(clear), .we(e_we), .lane_en(1'b1), .waddr(e_waddr),
        .wdata(wbyte), .raddr(rd_full[EA_W-1:0]), .rdata(e_rdata)
    );

    // Choose the reply byte: an echo after two bytes, read data after three.
    always_comb begin
        tx_byte = 8'h00;
        if (bit_cnt == 5'd16) begin
            if (rx_word[15:8] == OP_SPECIAL && rx_word[7:0] == SUB_ENABLE)
                tx_byte = rx_word[7:0];
        end else if (bit_cnt == 5'd24 && en_q) begin
            case (rx_word[23:16])
                OP_PRD_LO: tx_byte = p_rdata[7:0];
                OP_PRD_HI: tx_byte = p_rdata[15:8];
                OP_ERD:    tx_byte = e_rdata;
                default:   tx_byte = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/serprog_slave_chk.sv
// Checker for serprog_slave: properties on busy timing, the enable gate
// and the inactive link. It is bound to every instance of the top module.
module serprog_slave_chk #(
    parameter int BUSY_CYCLES = 2000
) (
    input logic clk,
    input logic rst_n,
    input logic miso,
    input logic busy,
    input logic frame_done,
    input logic en_q,
    input logic active
);
    logic [31:0] run_cnt;

    // Length of the current busy pulse in clk cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)     run_cnt <= '0;
        else if (busy)  run_cnt <= run_cnt + 1;
        else            run_cnt <= '0;
    end

    p_busy_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_cnt == BUSY_CYCLES)
        else $error("busy pulse length differs from BUSY_CYCLES");

    p_rel_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !busy && !miso)
        else $error("busy or miso set right after reset");

    p_busy_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(frame_done) && $past(en_q))
        else $error("busy rose without an enabled finished frame");

    p_quiet_miso_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && $past(!active)) |-> !miso)
        else $error("miso driven while link inactive");

    p_leave_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !en_q)
        else $error("enable survived an inactive link");

endmodule

bind serprog_slave serprog_slave_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .miso(miso), .busy(busy),
    .frame_done(frame_done), .en_q(en_q), .active(active)
);

// File: tb/sim_serprog_slave.sv
// Bench: drives full serial frames and compares replies with a model array held in the bench.
module sim_serprog_slave;
    localparam int HALF = 5;
    localparam int BUSY = 500;

    logic clk = 1'b0, rst_n = 1'b0, prog_rst_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso, busy;
    int   n_chk = 0, n_fail = 0;
    bit   done = 0;
    logic [7:0] ee_exp [64];

    always #5 clk = ~clk;

    serprog_slave #(.BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .prog_rst_n(prog_rst_n), .sck(sck),
        .mosi(mosi), .miso(miso), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] b0, b1, b2, b3,
                        output logic [7:0] r2, output logic [7:0] r3);
        logic [7:0] d;
        spi_byte(b0, d);
        spi_byte(b1, d);
        spi_byte(b2, r2);
        spi_byte(b3, r3);
        repeat (4) @(negedge clk);
    endtask

    task automatic idle_wait();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] b0, b1, b2, b3);
        logic [7:0] r2, r3;
        xfer(b0, b1, b2, b3, r2, r3);
        check("R10 write reply", {r2, r3}, 16'h0000);
        check("R8 busy after write", busy, 1);
        idle_wait();
    endtask

    function automatic logic [7:0] rd_ee(input logic [7:0] r3);
        return r3;
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r2, r3;
        repeat (4) @(negedge clk);
        check("R10 reset miso", miso, 0);
        check("R10 reset busy", busy, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: link inactive, a clear frame must do nothing
        xfer(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
        check("R1 no echo while inactive", r2, 8'h00);
        xfer(8'hAC, 8'h80, 8'h00, 8'h00, r2, r3);
        check("R1 busy while inactive", busy, 0);

        prog_rst_n = 1'b0;
        repeat (6) @(negedge clk);

        // R2: clear before enable is discarded; reads return 0
        xfer(8'hAC, 8'h80, 8'h00, 8'h00, r2, r3);
        check("R2 clear before enable", busy, 0);
        xfer(8'hA0, 8'h00, 8'h05, 8'h00, r2, r3);
        check("R2 read before enable", r3, 8'h00);

        // R3: enable echo
        xfer(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
        check("R3 echo byte", r2, 8'h53);
        check("R10 enable last byte", r3, 8'h00);

        // R4 and R8: clear, then a write during busy is ignored
        xfer(8'hAC, 8'h80, 8'h00, 8'h00, r2, r3);
        check("R8 busy after clear", busy, 1);
        xfer(8'hC0, 8'h00, 8'h00, 8'h12, r2, r3);
        check("R8 still busy", busy, 1);
        idle_wait();
        check("R8 busy released", busy, 0);
        for (int a = 0; a < 64; a += 9) begin
            xfer(8'hA0, 8'h00, 8'(a), 8'h00, r2, r3);
            check("R4 data cleared", r3, 8'hFF);
        end
        xfer(8'hA0, 8'h00, 8'h00, 8'h00, r2, r3);
        check("R8 write during busy ignored", r3, 8'hFF);
        for (int w = 0; w < 512; w += 73) begin
            xfer(8'h20, 8'(w >> 8), 8'(w), 8'h00, r2, r3);
            check("R4 prog low cleared", r3, 8'hFF);
            xfer(8'h28, 8'(w >> 8), 8'(w), 8'h00, r2, r3);
            check("R4 prog high cleared", r3, 8'hFF);
        end

        // R5: data array sweep, then overwrite without a clear
        for (int a = 0; a < 64; a++) begin
            ee_exp[a] = 8'((a * 37 + 5) & 8'hFF);
            wr(8'hC0, 8'h00, 8'(a), ee_exp[a]);
        end
        for (int a = 0; a < 8; a++) begin
            ee_exp[a] = ~ee_exp[a];
            wr(8'hC0, 8'h00, 8'(a), ee_exp[a]);
        end
        for (int a = 0; a < 64; a++) begin
            xfer(8'hA0, 8'h00, 8'(a), 8'h00, r2, r3);
            check("R10 read byte 2", r2, 8'h00);
            check("R5 data readback", rd_ee(r3), ee_exp[a]);
        end

        // R6: program array byte lanes
        for (int w = 0; w < 10; w++) begin
            wr(8'h40, 8'((w * 41) >> 8), 8'(w * 41), 8'((w * 29 + 3) & 8'hFF));
            wr(8'h48, 8'((w * 41) >> 8), 8'(w * 41), 8'((w * 11 + 8'h80) & 8'hFF));
        end
        for (int w = 0; w < 10; w++) begin
            xfer(8'h20, 8'((w * 41) >> 8), 8'(w * 41), 8'h00, r2, r3);
            check("R6 prog low", r3, (w * 29 + 3) & 8'hFF);
            xfer(8'h28, 8'((w * 41) >> 8), 8'(w * 41), 8'h00, r2, r3);
            check("R6 prog high", r3, (w * 11 + 8'h80) & 8'hFF);
        end

        // R7: address wrap in both arrays
        wr(8'hC0, 8'hFF, 8'h43, 8'hC3);
        xfer(8'hA0, 8'h00, 8'h03, 8'h00, r2, r3);
        check("R7 data wrap", r3, 8'hC3);
        wr(8'h40, 8'hFE, 8'h10, 8'h3C);
        xfer(8'h20, 8'h00, 8'h10, 8'h00, r2, r3);
        check("R7 prog wrap low", r3, 8'h3C);
        xfer(8'h20, 8'h02, 8'h10, 8'h00, r2, r3);
        check("R7 prog wrap upper bits", r3, 8'h3C);
        xfer(8'h28, 8'h00, 8'h10, 8'h00, r2, r3);
        check("R6 other lane untouched", r3, 8'hFF);

        // R9: leave mid-frame, then a new session needs enable again
        spi_byte(8'hC0, r2);
        spi_byte(8'h00, r2);
        prog_rst_n = 1'b1;
        repeat (6) @(negedge clk);
        // R1: write while inactive
        xfer(8'hC0, 8'h00, 8'h03, 8'h99, r2, r3);
        check("R1 busy inactive write", busy, 0);
        prog_rst_n = 1'b0;
        repeat (6) @(negedge clk);
        xfer(8'hC0, 8'h00, 8'h03, 8'h55, r2, r3);
        check("R9 write needs re-enable", busy, 0);
        xfer(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
        check("R9 counter realigned echo", r2, 8'h53);
        xfer(8'hA0, 8'h00, 8'h03, 8'h00, r2, r3);
        check("R9 data kept", r3, 8'hC3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule